// File: doc/BRIEF.md
# Watchdog and Alarm Down Counter

This block is a down counter with a seed register. Software loads it byte by byte, and it counts toward zero on one of two tick enables supplied from outside. In alarm mode it counts slow ticks (one per second). When it reaches zero it raises an alarm flag, reloads from the seed and carries on, so the flag recurs with a fixed period. In one-shot mode it counts fast ticks (4096 per second). When it expires it raises the flag, stops, and issues a fixed-length low pulse. The pulse goes either to the reset controller or to the active-low interrupt line, depending on a steering bit.

Any read or write of one of the counter bytes kicks the counter: it reloads from the seed and starts again. This is how the counter serves as a watchdog. If the counter is disabled, or the seed is all zeros, the bytes act as plain storage and no alarm is raised.

The expiry pulse lasts a fixed number of fast ticks. It cannot be cut short by software. It clears the flag as it ends.

Top module: `wdalarm_cnt`

## Requirements
- R1: A write to byte k (address 0, 1 or 2, where 0 is the least significant byte) replaces that byte of the seed and loads the whole counter from the resulting seed. Address 3 selects nothing, and a read there leaves `rdata_o` unchanged.
- R2: In alarm mode (`cfg_oneshot_i`=0) the counter decrements once per slow tick, and fast ticks are ignored. The tick that takes the count from 1 to 0 sets the flag and reloads the count from the seed, and counting continues.
- R3: In one-shot mode (`cfg_oneshot_i`=1) the counter decrements once per fast tick. Expiry sets the flag, and the counter then stays stopped until the next access.
- R4: With `cfg_enable_i`=1, a read or write of a counter byte reloads the count from the seed and restarts it. An access in the same cycle as the expiring tick takes precedence, so no flag is raised.
- R5: With `cfg_enable_i`=0 nothing counts and the bytes keep the values written. After the enable is raised, counting starts only at the next access. A seed of all zeros never raises the flag.
- R6: In alarm mode with `cfg_irq_en_i`=1, `irq_n_o` is low whenever the flag is set. A flag write of 0 clears the flag, and a flag write of 1 leaves it unchanged.
- R7: In one-shot mode, a pulse begins at the edge after the flag is set. With `cfg_steer_irq_i`=0 it drives `rst_req_o` high. With `cfg_steer_irq_i`=1 and `cfg_irq_en_i`=1 it drives `irq_n_o` low instead. With `cfg_steer_irq_i`=1 and `cfg_irq_en_i`=0 there is no pulse. A pulse lasts exactly PULSE_TICKS fast ticks.
- R8: Clearing the flag, or clearing `cfg_irq_en_i`, while a pulse is running does not shorten it.
- R9: The flag is cleared at the edge that ends a pulse.
- R10: A counter write during a pulse loads the count, but decrementing starts only after the pulse ends.
- R11: If the flag is already set when one-shot mode is selected, the steered pulse starts at the next edge.
- R12: One edge after a read, `rdata_o` holds the addressed byte of the count as it was at the access, not the reloaded value.
- R13: After reset the flag is 0, `irq_n_o` is 1, `rst_req_o` is 0, `rdata_o` is 0, the seed is zero and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_slow_i | input | 1 | One-cycle enable, once per second |
| tick_fast_i | input | 1 | One-cycle enable, 4096 per second |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | ADDR_W | Byte select |
| wdata_i | input | BYTE_W | Write data |
| rdata_o | output | BYTE_W | Byte captured by the last read |
| cfg_enable_i | input | 1 | Counter enable (0 = storage only) |
| cfg_oneshot_i | input | 1 | Mode: 0 = periodic alarm, 1 = one-shot watchdog |
| cfg_steer_irq_i | input | 1 | Pulse target: 0 = reset request, 1 = interrupt |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write value (only 0 has an effect) |
| flag_o | output | 1 | Alarm flag |
| irq_n_o | output | 1 | Interrupt request, active low |
| rst_req_o | output | 1 | Reset request pulse to the reset controller |

## Verification
A kick and an expiring tick can fall in the same cycle. The bench brings the count down to 1, then drives a slow tick and a byte read in the same cycle. It expects no flag, and `rdata_o` equal to 1. It then expects the full seed period to elapse before the next flag. A counter write during a running pulse is a second collision. In that case the bench expects the pulse to run to its full length, the flag to clear as the pulse ends, and a fresh expiry only after the pulse.

// File: rtl/wda_pkg.sv
`timescale 1ns/1ps
package wda_pkg;
   typedef enum logic {
      PT_RESET = 1'b0,
      PT_IRQ   = 1'b1
   } pulse_tgt_e;
endpackage

// File: rtl/wda_counter.sv
`timescale 1ns/1ps
module wda_counter #(
   parameter  int CNT_W  = 24,
   parameter  int BYTE_W = 8,
   localparam int NB     = CNT_W / BYTE_W,
   localparam int AW     = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              oneshot_i,
   input  logic              tick_slow_i,
   input  logic              tick_fast_i,
   input  logic              hold_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [AW-1:0]     addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   output logic              expire_o
);
   logic [CNT_W-1:0]  cnt_q, seed_q, seed_nxt;
   logic [BYTE_W-1:0] rd_byte;
   logic              run_q, addr_ok, acc, step, at_end, advance;

   assign addr_ok = int'(addr_i) < NB;
   assign acc     = (wr_en_i | rd_en_i) & addr_ok;
   assign step    = oneshot_i ? tick_fast_i : tick_slow_i;
   assign at_end  = (cnt_q <= CNT_W'(1));
   assign advance = en_i & run_q & ~hold_i & step & ~acc;
   assign expire_o = advance & at_end;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      assign seed_nxt[b*BYTE_W +: BYTE_W] =
         (wr_en_i && int'(addr_i) == b) ? wdata_i : seed_q[b*BYTE_W +: BYTE_W];
   end

   always_comb begin
      rd_byte = '0;
      for (int b = 0; b < NB; b++) begin
         if (int'(addr_i) == b) rd_byte = cnt_q[b*BYTE_W +: BYTE_W];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         seed_q  <= '0;
         run_q   <= 1'b0;
         rdata_o <= '0;
      end else begin
         if (wr_en_i & addr_ok) seed_q <= seed_nxt;
         if (rd_en_i & addr_ok) rdata_o <= rd_byte;
         if (acc) begin
            cnt_q <= seed_nxt;
            run_q <= en_i & (seed_nxt != '0);
         end else if (!en_i) begin
            run_q <= 1'b0;
         end else if (advance) begin
            if (at_end) begin
               if (oneshot_i) begin
                  cnt_q <= '0;
                  run_q <= 1'b0;
               end else begin
                  cnt_q <= seed_q;
               end
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/wda_pulse.sv
`timescale 1ns/1ps
module wda_pulse
   import wda_pkg::*;
#(
   parameter  int PULSE_TICKS = 1024,
   localparam int PW          = $clog2(PULSE_TICKS + 1)
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  pulse_tgt_e tgt_i,
   input  logic       tick_i,
   output logic       active_o,
   output pulse_tgt_e tgt_o,
   output logic       done_o
);
   logic [PW-1:0] left_q;

   assign done_o = active_o & tick_i & (left_q == PW'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         active_o <= 1'b0;
         tgt_o    <= PT_RESET;
         left_q   <= '0;
      end else if (start_i & ~active_o) begin
         active_o <= 1'b1;
         tgt_o    <= tgt_i;
         left_q   <= PW'(PULSE_TICKS);
      end else if (active_o & tick_i) begin
         if (left_q == PW'(1)) active_o <= 1'b0;
         left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/wdalarm_cnt.sv
`timescale 1ns/1ps
module wdalarm_cnt
   import wda_pkg::*;
#(
   parameter  int CNT_W       = 24,
   parameter  int BYTE_W      = 8,
   parameter  int PULSE_TICKS = 1024,
   localparam int NB          = CNT_W / BYTE_W,
   localparam int ADDR_W      = (NB > 1) ? $clog2(NB) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_slow_i,
   input  logic              tick_fast_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] rdata_o,
   input  logic              cfg_enable_i,
   input  logic              cfg_oneshot_i,
   input  logic              cfg_steer_irq_i,
   input  logic              cfg_irq_en_i,
   input  logic              flag_wr_i,
   input  logic              flag_wdata_i,
   output logic              flag_o,
   output logic              irq_n_o,
   output logic              rst_req_o
);
   if (CNT_W % BYTE_W != 0 || NB < 1) begin : g_bad_width
      $error("CNT_W must be a nonzero multiple of BYTE_W");
   end
   if (PULSE_TICKS < 2) begin : g_bad_pulse
      $error("PULSE_TICKS must be at least 2");
   end

   logic       expire, pulse_on, pulse_done, pulse_start, flag_q;
   pulse_tgt_e pulse_tgt, tgt_sel;

   wda_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (cfg_enable_i),
      .oneshot_i  (cfg_oneshot_i),
      .tick_slow_i(tick_slow_i),
      .tick_fast_i(tick_fast_i),
      .hold_i     (pulse_on),
      .wr_en_i    (wr_en_i),
      .rd_en_i    (rd_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .expire_o   (expire)
   );

   assign tgt_sel     = cfg_steer_irq_i ? PT_IRQ : PT_RESET;
   assign pulse_start = cfg_oneshot_i & flag_q & ~pulse_on
                      & (~cfg_steer_irq_i | cfg_irq_en_i);

   wda_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (pulse_start),
      .tgt_i   (tgt_sel),
      .tick_i  (tick_fast_i),
      .active_o(pulse_on),
      .tgt_o   (pulse_tgt),
      .done_o  (pulse_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         flag_q <= 1'b0;
      else if (expire)                     flag_q <= 1'b1;
      else if (pulse_done)                 flag_q <= 1'b0;
      else if (flag_wr_i & ~flag_wdata_i)  flag_q <= 1'b0;
   end

   assign flag_o    = flag_q;
   assign rst_req_o = pulse_on & (pulse_tgt == PT_RESET);
   assign irq_n_o   = ~((pulse_on & (pulse_tgt == PT_IRQ))
                      | (~cfg_oneshot_i & flag_q & cfg_irq_en_i));
endmodule

// File: rtl/wdalarm_cnt_chk.sv
`timescale 1ns/1ps
module wdalarm_cnt_chk #(
   parameter int ADDR_W = 2,
   parameter int NB     = 3
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_slow_i,
   input logic              tick_fast_i,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              flag_o,
   input logic              rst_req_o
);
   // R8
   pulse_end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_req_o) |-> $past(tick_fast_i));
   // R9
   pulse_clears_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_req_o) |-> !flag_o);
   // R2
   flag_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> $past(tick_slow_i | tick_fast_i));
   // R4
   kick_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> !$past((wr_en_i | rd_en_i) && (int'(addr_i) < NB)));
   // R7
   pulse_min_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_req_o) |=> rst_req_o);
endmodule

bind wdalarm_cnt wdalarm_cnt_chk #(.ADDR_W(ADDR_W), .NB(NB)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tick_slow_i(tick_slow_i),
   .tick_fast_i(tick_fast_i),
   .wr_en_i    (wr_en_i),
   .rd_en_i    (rd_en_i),
   .addr_i     (addr_i),
   .flag_o     (flag_o),
   .rst_req_o  (rst_req_o)
);

// File: tb/wdalarm_cnt_tb_top.sv
`timescale 1ns/1ps
module wdalarm_cnt_tb_top;
   localparam int PT = 1024;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       ts = 1'b0, tf = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wd = '0;
   logic       en = 1'b0, os = 1'b0, steer = 1'b0, aie = 1'b0, fwr = 1'b0, fwd = 1'b0;
   logic [7:0] rdata;
   logic       flag, irq_n, rst_req;
   bit         auto_fast = 1'b1;
   int         n_chk = 0, n_bad = 0, div = 0;

   // reference model state
   int m_cnt, m_seed, m_rd, m_pcnt;
   bit m_run, m_flag, m_pact, m_ptgt;

   always #4 clk = ~clk;

   wdalarm_cnt dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_slow_i(ts), .tick_fast_i(tf),
      .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr), .wdata_i(wd), .rdata_o(rdata),
      .cfg_enable_i(en), .cfg_oneshot_i(os), .cfg_steer_irq_i(steer),
      .cfg_irq_en_i(aie), .flag_wr_i(fwr), .flag_wdata_i(fwd),
      .flag_o(flag), .irq_n_o(irq_n), .rst_req_o(rst_req));

   always @(negedge clk) begin
      if (!rst_n) begin div = 0; tf = 1'b0; end
      else begin div = (div + 1) % 4; tf = auto_fast && (div == 0); end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_seed = 0; m_rd = 0; m_pcnt = 0;
         m_run = 0; m_flag = 0; m_pact = 0; m_ptgt = 0;
      end else begin
         bit acc, stp, ex, pend, start;
         int snx;
         acc = (wr || rd) && addr < 3;
         snx = m_seed;
         if (wr && addr < 3) snx = (snx & ~(255 << (8*addr))) | (int'(wd) << (8*addr));
         stp = os ? tf : ts;
         ex = en && m_run && !m_pact && stp && !acc && m_cnt <= 1;
         pend = m_pact && tf && m_pcnt == 1;
         start = os && m_flag && !m_pact && (!steer || aie);
         if (rd && acc) m_rd = (m_cnt >> (8*addr)) & 255;
         if (acc) begin m_cnt = snx; m_run = en && snx != 0; end
         else if (!en) m_run = 0;
         else if (m_run && !m_pact && stp) begin
            if (m_cnt <= 1) begin
               if (os) begin m_cnt = 0; m_run = 0; end else m_cnt = m_seed;
            end else m_cnt = m_cnt - 1;
         end
         m_seed = snx;
         if (ex) m_flag = 1;
         else if (pend) m_flag = 0;
         else if (fwr && !fwd) m_flag = 0;
         if (start) begin m_pact = 1; m_ptgt = steer; m_pcnt = PT; end
         else if (m_pact && tf) begin
            if (m_pcnt == 1) m_pact = 0;
            m_pcnt = m_pcnt - 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   // per-cycle comparison with the model
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         chk_eq("R6 model flag", int'(flag), int'(m_flag));
         chk_eq("R7 model rst_req", int'(rst_req), int'(m_pact && !m_ptgt));
         chk_eq("R7 model irq_n", int'(irq_n),
                int'(!((m_pact && m_ptgt) || (!os && m_flag && aie))));
         chk_eq("R12 model rdata", int'(rdata), m_rd);
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic op(input bit w, input bit r, input int a, input int d, input bit slow);
      wr = w; rd = r; addr = 2'(a); wd = 8'(d); ts = slow;
      tick();
      wr = 0; rd = 0; ts = 0;
   endtask

   task automatic slow_tick();
      op(0, 0, 0, 0, 1);
   endtask

   task automatic flag_write(input bit v);
      fwr = 1; fwd = v; tick(); fwr = 0;
   endtask

   task automatic wait_flag(input bit v, input int maxc, input string req);
      for (int i = 0; i < maxc && flag != v; i++) tick();
      chk_eq(req, int'(flag), int'(v));
   endtask

   function automatic bit pulse_on(input bit is_rst);
      return is_rst ? rst_req : !irq_n;
   endfunction

   task automatic measure(input bit is_rst, input int pokes, output int n, output bit other);
      int k = 0;
      n = 0; other = 0;
      for (int i = 0; i < 20 && !pulse_on(is_rst); i++) tick();
      while (pulse_on(is_rst) && k < 10000) begin
         if (tf) n++;
         if (is_rst ? !irq_n : rst_req) other = 1;
         if (pokes > 0 && k == 20) begin fwr = 1; fwd = 0; aie = 0; end
         if (k == 21) fwr = 0;
         if (pokes > 1 && k == 30) begin wr = 1; addr = 0; wd = 8'd2; end
         if (k == 31) wr = 0;
         if (pokes > 0 && k == 25) chk_eq("R8 flag cleared mid-pulse", int'(flag), 0);
         k++;
         tick();
      end
   endtask

   initial begin
      int n;
      bit other;
      repeat (5) tick();
      rst_n = 1;
      // R13 reset state
      chk_eq("R13 flag", int'(flag), 0);
      chk_eq("R13 irq_n", int'(irq_n), 1);
      chk_eq("R13 rst_req", int'(rst_req), 0);
      chk_eq("R13 rdata", int'(rdata), 0);

      // R1 / R5: storage with enable low
      op(1, 0, 0, 8'h05, 0); op(1, 0, 1, 8'hA1, 0); op(1, 0, 2, 8'h3C, 0);
      repeat (3) slow_tick();
      op(0, 1, 0, 0, 0); chk_eq("R1 byte0", int'(rdata), 8'h05);
      op(0, 1, 1, 0, 0); chk_eq("R1 byte1", int'(rdata), 8'hA1);
      op(0, 1, 2, 0, 0); chk_eq("R5 byte2 kept while disabled", int'(rdata), 8'h3C);
      op(0, 1, 3, 0, 0); chk_eq("R1 address 3 ignored", int'(rdata), 8'h3C);
      chk_eq("R5 no flag while disabled", int'(flag), 0);

      // R2 / R6: periodic alarm
      en = 1; aie = 1;
      op(1, 0, 0, 3, 0); op(1, 0, 1, 0, 0); op(1, 0, 2, 0, 0);
      slow_tick(); slow_tick();
      chk_eq("R2 no flag before zero", int'(flag), 0);
      slow_tick();
      chk_eq("R2 flag at zero", int'(flag), 1);
      chk_eq("R6 irq low with flag", int'(irq_n), 0);
      op(0, 1, 0, 0, 0); chk_eq("R2 reloaded from seed", int'(rdata), 3);
      flag_write(1); chk_eq("R6 write 1 ignored", int'(flag), 1);
      flag_write(0); chk_eq("R6 write 0 clears", int'(flag), 0);
      chk_eq("R6 irq released", int'(irq_n), 1);

      // R4 / R12: kick, including kick in the expiring cycle
      slow_tick(); slow_tick();
      op(0, 1, 0, 0, 1);
      chk_eq("R4 kick beats expiry", int'(flag), 0);
      chk_eq("R12 read value at access", int'(rdata), 1);
      slow_tick(); slow_tick();
      chk_eq("R4 restarted full period", int'(flag), 0);
      slow_tick();
      chk_eq("R4 flag after restart", int'(flag), 1);
      flag_write(0);

      // R5: zero seed, disable, enable without access
      op(1, 0, 0, 0, 0);
      repeat (4) slow_tick();
      chk_eq("R5 zero seed never flags", int'(flag), 0);
      en = 0; op(1, 0, 0, 2, 0);
      repeat (4) slow_tick();
      en = 1;
      repeat (4) slow_tick();
      chk_eq("R5 waits for access after enable", int'(flag), 0);

      // R3 / R7 / R8 / R9: one-shot, reset target
      os = 1; steer = 0; aie = 0;
      op(1, 0, 0, 5, 0);
      wait_flag(1, 80, "R3 one-shot expiry");
      measure(1, 1, n, other);
      chk_eq("R7 reset pulse length", n, PT);
      chk_eq("R7 irq quiet during reset pulse", int'(other), 0);
      chk_eq("R9 flag cleared at end", int'(flag), 0);
      repeat (200) tick();
      chk_eq("R3 stopped after expiry", int'(flag), 0);

      // R7 / R8 / R10: interrupt target, write during pulse
      steer = 1; aie = 1;
      op(1, 0, 0, 4, 0);
      wait_flag(1, 80, "R3 second expiry");
      measure(0, 2, n, other);
      chk_eq("R8 irq pulse not truncated", n, PT);
      chk_eq("R7 reset quiet during irq pulse", int'(other), 0);
      chk_eq("R9 flag cleared at irq pulse end", int'(flag), 0);
      wait_flag(1, 40, "R10 count resumes after pulse");
      repeat (10) tick();
      chk_eq("R7 no pulse when irq disabled", int'(irq_n), 1);
      chk_eq("R7 no reset when steered to irq", int'(rst_req), 0);

      // R11: flag pending when one-shot is selected
      os = 0; tick();
      chk_eq("R11 alarm mode irq off", int'(irq_n), 1);
      os = 1; steer = 0; tick();
      chk_eq("R11 pulse starts at once", int'(rst_req), 1);
      measure(1, 0, n, other);
      chk_eq("R11 pulse length", n, PT);
      chk_eq("R9 flag cleared after R11 pulse", int'(flag), 0);

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 180000);
      n_chk++; n_bad++;
      $display("FAIL watchdog R13 actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule